// File: doc/BRIEF.md
# PCM Line Code Decoder with Derandomizer

This block takes hard-decision line symbols that a bit synchronizer has already recovered, together with a one-cycle symbol strobe in the system clock domain, and turns them into plain level-coded data. A run-time select picks the line code: level, mark-transition, space-transition, split-phase (two half-bit symbols per data bit), or level code that has passed through a self-synchronizing scrambler. For the scrambled code, a second select sets the scrambler register length to 11, 13, 15, 17 or 23 stages. An optional inversion is applied to every symbol before any decoding.

The block also watches the line for a channel that has gone dead. It counts how many identical symbols have arrived in a row and raises a flag once that count reaches a programmable limit. A typical limit is 48. With split-phase or scrambled codes the line always toggles, so the flag stays low in normal operation. Invalid split-phase pairs are reported on a separate error pulse. The code select and scrambler length are meant to stay static between resets.

Top module: `pcm_line_decoder`

## Requirements
- R1: While `rst_n` is low, `dec_valid`, `dec_data`, `stuck` and `pair_err` are all 0.
- R2: When `invert_in` is 1, each symbol is complemented before decoding and before stuck counting. The "level" below is `sym_in ^ invert_in`.
- R3: With `code_sel` = 0 (level code), `dec_valid` pulses in the cycle after each `sym_en` cycle and `dec_data` equals that symbol's level. `dec_valid` never pulses unless `sym_en` was high in the previous cycle.
- R4: With `code_sel` = 1 (mark), `dec_data` is 1 when the level differs from the previous symbol's level. The previous level is 0 after reset.
- R5: With `code_sel` = 2 (space), `dec_data` is 1 when the level equals the previous symbol's level. The previous level is 0 after reset.
- R6: With `code_sel` = 3 (split-phase), symbols pair up starting with the first symbol after reset. A pair of high then low gives 1, and low then high gives 0. `dec_valid` pulses only in the cycle after the second symbol of a pair.
- R7: In split-phase mode, a pair with two equal levels produces a one-cycle `pair_err` pulse in place of `dec_valid`.
- R8: With `code_sel` = 4 (scrambled), `dec_data` = level ^ h[a] ^ h[b]. Here h[k] is the level k symbols earlier, and h is 0 after reset. The history advances on every symbol in every mode. `lfsr_order` 0..4 select the tap pairs (a,b): (9,11), (10,13), (14,15), (14,17) and (18,23). Values 5..7 select (14,15).
- R9: The run length counts identical consecutive levels, including the current one. After reset the previous level is 0 and the run is 0. `stuck` is updated in the cycle after each symbol to (run >= `stuck_limit`) and does not change without a symbol.
- R10: The run counter saturates at 2^RUN_W-1 instead of wrapping. With `stuck_limit` at that maximum, `stuck` stays high over arbitrarily long runs.
- R11: With `code_sel` 5..7, neither `dec_valid` nor `pair_err` ever pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | One-cycle strobe marking a new line symbol |
| sym_in | input | 1 | Line symbol value |
| code_sel | input | 3 | Line code select (0 level, 1 mark, 2 space, 3 split-phase, 4 scrambled) |
| invert_in | input | 1 | Complement symbols before decoding |
| lfsr_order | input | 3 | Scrambler length select (0:11, 1:13, 2:15, 3:17, 4:23 stages) |
| stuck_limit | input | RUN_W | Run length at which the channel is declared stuck |
| dec_data | output | 1 | Decoded level-code data bit |
| dec_valid | output | 1 | One-cycle strobe qualifying `dec_data` |
| stuck | output | 1 | Channel shows no transitions for `stuck_limit` symbols |
| pair_err | output | 1 | One-cycle strobe on an invalid split-phase pair |

## Verification
Every result, whether the decoded bit with its strobe, the split-phase error or the stuck flag, is registered once. Each result therefore appears on the first rising edge after the cycle in which `sym_en` was high. The bench raises `sym_en` on a falling edge for one cycle and compares all outputs on the following falling edge, which falls midway between that result edge and the next. Random idle cycles between symbols are checked as well: in those cycles no strobe may appear and the stuck flag must hold.

// File: rtl/pcm_dec_pkg.sv
package pcm_dec_pkg;

   typedef enum logic [2:0] {
      LC_LEVEL = 3'd0,
      LC_MARK  = 3'd1,
      LC_SPACE = 3'd2,
      LC_SPLIT = 3'd3,
      LC_SCRAM = 3'd4
   } line_code_e;

   localparam int unsigned NUM_ORDERS    = 5;
   localparam int unsigned HIST_LEN      = 23;
   localparam int unsigned DEFAULT_ORDER = 2;

   // Tap pairs per length option: near tap and far tap (far tap = register length)
   localparam int unsigned TAP_NEAR [NUM_ORDERS] = '{9, 10, 14, 14, 18};
   localparam int unsigned TAP_FAR  [NUM_ORDERS] = '{11, 13, 15, 17, 23};

endpackage

// File: rtl/pcm_sym_front.sv
module pcm_sym_front #(
   parameter int unsigned RUN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_en,
   input  logic             sym_in,
   input  logic             invert_in,
   input  logic [RUN_W-1:0] stuck_limit,
   output logic             lvl,
   output logic             prev_lvl,
   output logic             stuck
);
   localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
   localparam logic [RUN_W-1:0] RUN_ONE = {{(RUN_W-1){1'b0}}, 1'b1};

   if (RUN_W < 2) begin : g_bad_run_w
      $error("pcm_sym_front: RUN_W must be at least 2");
   end

   logic             prev_q;
   logic             stuck_q;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nxt;

   assign lvl      = sym_in ^ invert_in;
   assign prev_lvl = prev_q;
   assign stuck    = stuck_q;

   always_comb begin
      if (lvl != prev_q)        run_nxt = RUN_ONE;
      else if (run_q == RUN_MAX) run_nxt = RUN_MAX;
      else                      run_nxt = run_q + RUN_ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         run_q   <= '0;
         stuck_q <= 1'b0;
      end else if (sym_en) begin
         prev_q  <= lvl;
         run_q   <= run_nxt;
         stuck_q <= (run_nxt >= stuck_limit);
      end
   end

   // R10
   run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && lvl == prev_q && run_q == RUN_MAX) |=> (run_q == RUN_MAX));

   // R9
   stuck_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && lvl != prev_q && stuck_limit > RUN_ONE) |=> !stuck_q);

   // R9
   stuck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_en |=> $stable(stuck_q));

endmodule

// File: rtl/pcm_derand.sv
module pcm_derand
   import pcm_dec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sym_en,
   input  logic       lvl,
   input  logic [2:0] order_sel,
   output logic       rand_bit
);
   logic [HIST_LEN-1:0]   hist_q;
   logic [NUM_ORDERS-1:0] opt_x;
   logic                  sel_x;

   for (genvar i = 0; i < NUM_ORDERS; i++) begin : g_opt
      if (TAP_FAR[i] > HIST_LEN || TAP_NEAR[i] >= TAP_FAR[i] || TAP_NEAR[i] < 1) begin : g_bad_tap
         $error("pcm_derand: tap pair out of range");
      end
      assign opt_x[i] = hist_q[TAP_NEAR[i]-1] ^ hist_q[TAP_FAR[i]-1];
   end

   always_comb begin
      sel_x = opt_x[DEFAULT_ORDER];
      for (int i = 0; i < NUM_ORDERS; i++) begin
         if (order_sel == 3'(i)) sel_x = opt_x[i];
      end
   end

   assign rand_bit = lvl ^ sel_x;

   always_ff @(posedge clk) begin
      if (!rst_n)      hist_q <= '0;
      else if (sym_en) hist_q <= {hist_q[HIST_LEN-2:0], lvl};
   end

   // R8
   hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_en |=> $stable(hist_q));

endmodule

// File: rtl/pcm_split_pair.sv
module pcm_split_pair (
   input  logic clk,
   input  logic rst_n,
   input  logic sym_en,
   input  logic active,
   input  logic lvl,
   output logic pair_done,
   output logic pair_bit,
   output logic pair_bad
);
   logic phase_q;
   logic first_q;
   logic step;

   assign step      = sym_en & active;
   assign pair_done = step & phase_q & (first_q != lvl);
   assign pair_bad  = step & phase_q & (first_q == lvl);
   assign pair_bit  = first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         first_q <= 1'b0;
      end else if (step) begin
         phase_q <= ~phase_q;
         if (!phase_q) first_q <= lvl;
      end
   end

   // R6
   phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/pcm_line_decoder.sv
module pcm_line_decoder
   import pcm_dec_pkg::*;
#(
   parameter int unsigned RUN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_en,
   input  logic             sym_in,
   input  logic [2:0]       code_sel,
   input  logic             invert_in,
   input  logic [2:0]       lfsr_order,
   input  logic [RUN_W-1:0] stuck_limit,
   output logic             dec_data,
   output logic             dec_valid,
   output logic             stuck,
   output logic             pair_err
);
   line_code_e code_e;
   logic lvl, prev_lvl, rand_bit;
   logic pair_done, pair_bit, pair_bad;
   logic nv, nd, ne;
   logic valid_q, data_q, err_q;

   assign code_e = line_code_e'(code_sel);

   pcm_sym_front #(.RUN_W(RUN_W)) front_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_en      (sym_en),
      .sym_in      (sym_in),
      .invert_in   (invert_in),
      .stuck_limit (stuck_limit),
      .lvl         (lvl),
      .prev_lvl    (prev_lvl),
      .stuck       (stuck)
   );

   pcm_derand derand_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym_en    (sym_en),
      .lvl       (lvl),
      .order_sel (lfsr_order),
      .rand_bit  (rand_bit)
   );

   pcm_split_pair split_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym_en    (sym_en),
      .active    (code_e == LC_SPLIT),
      .lvl       (lvl),
      .pair_done (pair_done),
      .pair_bit  (pair_bit),
      .pair_bad  (pair_bad)
   );

   always_comb begin
      nv = 1'b0;
      nd = 1'b0;
      ne = 1'b0;
      case (code_e)
         LC_LEVEL: begin nv = sym_en; nd = lvl;                end
         LC_MARK:  begin nv = sym_en; nd = lvl ^ prev_lvl;     end
         LC_SPACE: begin nv = sym_en; nd = ~(lvl ^ prev_lvl);  end
         LC_SPLIT: begin nv = pair_done; nd = pair_bit; ne = pair_bad; end
         LC_SCRAM: begin nv = sym_en; nd = rand_bit;           end
         default:  begin nv = 1'b0; nd = 1'b0; ne = 1'b0;      end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         valid_q <= nv;
         err_q   <= ne;
         if (nv) data_q <= nd;
      end
   end

   assign dec_valid = valid_q;
   assign dec_data  = data_q;
   assign pair_err  = err_q;

   // R3
   valid_needs_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(sym_en));

   // R3
   level_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && code_sel == 3'd0) |=> (dec_valid && dec_data == $past(sym_in ^ invert_in)));

   // R7
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_err |-> !dec_valid);

   // R11
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_sel > 3'd4) |=> (!dec_valid && !pair_err));

endmodule

// File: tb/pcm_line_decoder_tb_top.sv
`timescale 1ns/1ps
module pcm_line_decoder_tb_top;
   localparam int RUN_W   = 8;
   localparam int RUN_MAX = (1 << RUN_W) - 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             sym_en = 1'b0;
   logic             sym_in = 1'b0;
   logic [2:0]       code_sel = 3'd0;
   logic             invert_in = 1'b0;
   logic [2:0]       lfsr_order = 3'd0;
   logic [RUN_W-1:0] stuck_limit = 8'd48;
   logic dec_data, dec_valid, stuck, pair_err;

   pcm_line_decoder #(.RUN_W(RUN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .sym_in(sym_in),
      .code_sel(code_sel), .invert_in(invert_in), .lfsr_order(lfsr_order),
      .stuck_limit(stuck_limit), .dec_data(dec_data), .dec_valid(dec_valid),
      .stuck(stuck), .pair_err(pair_err)
   );

   int checks = 0;
   int errors = 0;

   // reference state
   bit m_prev;
   bit m_hist [1:23];
   int m_run;
   bit m_phase, m_h1, m_stuck;

   function automatic int tap_near(int o);
      case (o)
         0: return 9;  1: return 10; 3: return 14; 4: return 18;
         default: return 14;
      endcase
   endfunction

   function automatic int tap_far(int o);
      case (o)
         0: return 11; 1: return 13; 3: return 17; 4: return 23;
         default: return 15;
      endcase
   endfunction

   task automatic check_bit(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string code_tag(int c);
      case (c)
         0: return "R3"; 1: return "R4"; 2: return "R5";
         3: return "R6"; 4: return "R8"; default: return "R11";
      endcase
   endfunction

   task automatic do_reset();
      rst_n  = 1'b0;
      sym_en = 1'b0;
      repeat (3) @(negedge clk);
      check_bit("R1 dec_valid", dec_valid, 1'b0);
      check_bit("R1 dec_data", dec_data, 1'b0);
      check_bit("R1 stuck", stuck, 1'b0);
      check_bit("R1 pair_err", pair_err, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      m_prev = 0; m_run = 0; m_phase = 0; m_h1 = 0; m_stuck = 0;
      for (int k = 1; k <= 23; k++) m_hist[k] = 0;
   endtask

   // drive one symbol at a falling edge; compare at the next falling edge
   task automatic send(bit b);
      bit d, ev, ed, ee;
      int c;
      string tag;
      c  = int'(code_sel);
      d  = b ^ invert_in;
      ev = 0; ed = 0; ee = 0;
      case (c)
         0: begin ev = 1; ed = d; end
         1: begin ev = 1; ed = d ^ m_prev; end
         2: begin ev = 1; ed = ~(d ^ m_prev); end
         3: begin
            if (!m_phase) m_h1 = d;
            else if (m_h1 != d) begin ev = 1; ed = m_h1; end
            else ee = 1;
            m_phase = ~m_phase;
         end
         4: begin
            ev = 1;
            ed = d ^ m_hist[tap_near(int'(lfsr_order))] ^ m_hist[tap_far(int'(lfsr_order))];
         end
         default: ;
      endcase
      if (d == m_prev) m_run = (m_run == RUN_MAX) ? RUN_MAX : m_run + 1;
      else m_run = 1;
      m_stuck = (m_run >= int'(stuck_limit));
      for (int k = 23; k >= 2; k--) m_hist[k] = m_hist[k-1];
      m_hist[1] = d;
      m_prev = d;

      sym_in = b;
      sym_en = 1'b1;
      @(negedge clk);
      sym_en = 1'b0;
      tag = code_tag(c);
      if (invert_in) tag = {tag, "/R2"};
      check_bit({tag, " dec_valid"}, dec_valid, ev);
      if (ev) check_bit({tag, " dec_data"}, dec_data, ed);
      check_bit((c == 3) ? "R7 pair_err" : {tag, " pair_err"}, pair_err, ee);
      check_bit("R9 stuck", stuck, m_stuck);
   endtask

   task automatic idle();
      @(negedge clk);
      check_bit("R3 idle dec_valid", dec_valid, 1'b0);
      check_bit("R7 idle pair_err", pair_err, 1'b0);
      check_bit("R9 idle stuck", stuck, m_stuck);
   endtask

   task automatic random_run(int n);
      for (int i = 0; i < n; i++) begin
         if (code_sel == 3'd3) begin
            bit b1;
            b1 = 1'($urandom & 1);
            send(b1);
            send(($urandom % 16 == 0) ? b1 : ~b1);
         end else begin
            send(($urandom % 4 == 0) ? m_prev ^ invert_in : 1'($urandom & 1));
         end
         if ($urandom % 8 == 0) idle();
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      @(negedge clk);

      // random mix across codes, polarities and scrambler lengths
      for (int pol = 0; pol < 2; pol++) begin
         for (int c = 0; c < 5; c++) begin
            int norders;
            norders = (c == 4) ? 8 : 1;
            for (int o = 0; o < norders; o++) begin
               code_sel    = 3'(c);
               invert_in   = 1'(pol);
               lfsr_order  = 3'(o);
               stuck_limit = RUN_W'(2 + $urandom % 6);
               do_reset();
               random_run(120);
            end
         end
      end

      // R2 directed: inverted level code
      code_sel = 3'd0; invert_in = 1'b1; stuck_limit = 8'd48;
      do_reset();
      send(1'b1);
      check_bit("R2 inverted one", dec_data, 1'b0);
      send(1'b0);
      check_bit("R2 inverted zero", dec_data, 1'b1);

      // R9 directed: threshold 5 on a run of ones
      invert_in = 1'b0; stuck_limit = 8'd5;
      do_reset();
      for (int i = 0; i < 4; i++) send(1'b1);
      check_bit("R9 below limit", stuck, 1'b0);
      send(1'b1);
      check_bit("R9 at limit", stuck, 1'b1);
      idle();
      send(1'b0);
      check_bit("R9 cleared on transition", stuck, 1'b0);

      // R10 directed: saturation with the largest limit
      stuck_limit = 8'(RUN_MAX);
      do_reset();
      for (int i = 0; i < 300; i++) send(1'b0);
      check_bit("R10 saturated run keeps stuck", stuck, 1'b1);

      // R6 directed: split-phase pairs
      code_sel = 3'd3; stuck_limit = 8'd48;
      do_reset();
      send(1'b1); send(1'b0);
      check_bit("R6 high-low gives one", dec_data, 1'b1);
      send(1'b0); send(1'b1);
      check_bit("R6 low-high gives zero", dec_data, 1'b0);
      send(1'b1); send(1'b1);
      check_bit("R7 equal pair flagged", pair_err, 1'b1);

      // R11 directed: unused codes
      for (int c = 5; c < 8; c++) begin
         code_sel = 3'(c);
         do_reset();
         random_run(20);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule